// File: doc/BRIEF.md
# Dual 40-bit Accumulator with Saturation and Rounding

This block keeps two 40-bit signed accumulators, called A and B, and updates one of them per cycle through a single 41-bit add/subtract path. An operation arrives with a valid strobe, an operation code, an accumulator select and a 40-bit operand, which is typically a sign-extended multiplier product. The operation can load the operand, add it, or subtract it. It can also combine the two accumulators with no operand at all: their sum, the target minus the other, or the negated target.

Each accumulator has its own saturation enable. A shared mode input picks the clamp limits: either the 32-bit signed range or the full 40-bit range. When a write is clamped, a sticky overflow flag for that accumulator is set. The flag stays set until the clear input is raised.

A combinational store port rounds the selected accumulator to a 16-bit word taken from bits 31..16. Rounding is conventional or convergent. A separate enable decides whether out-of-range words are clamped.

Top module: `dual_acc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both accumulators become zero and both overflow flags become 0.
- R2: With `op_valid` high, op code 1 (load) writes `operand` into the accumulator chosen by `acc_sel` (0 = A, 1 = B). The other accumulator is left unchanged.
- R3: Op code 2 writes target + `operand` and op code 3 writes target − `operand`. Both use signed 40-bit values.
- R4: The operand is ignored by three codes. Code 4 writes A + B into the target. Code 5 writes the target minus the other accumulator. Code 6 writes the negated target.
- R5: When the target's saturation enable is 0, its result wraps modulo 2^40 and the write does not set its overflow flag.
- R6: When the target's saturation enable is 1 and `sat_wide` is 0, the result is clamped to 0x00_7FFF_FFFF .. 0xFF_8000_0000. A clamp sets the target's overflow flag.
- R7: When the target's saturation enable is 1 and `sat_wide` is 1, the result is clamped to 0x7F_FFFF_FFFF .. 0x80_0000_0000. A clamp sets the target's overflow flag.
- R8: Only the enable that belongs to the target accumulator (`sat_en_a` for A, `sat_en_b` for B) affects a write.
- R9: An overflow flag stays set until a cycle with `clr_ovf` high clears it. A clamp in that same cycle keeps the flag set.
- R10: With `rnd_conv` = 0, `store_word` is bits 31..16 of the selected accumulator. Before those bits are taken, 0x1_0000 is added when bit 15 is 1.
- R11: With `rnd_conv` = 1, rounding is the same as R10 except in one case. When bits 15..0 equal exactly 0x8000, the increment is applied only if bit 16 is 1, so the result is even.
- R12: With `store_sat_en` = 1, a rounded value above 0x7FFF_FFFF stores 0x7FFF and a rounded value below −2^31 stores 0x8000. With `store_sat_en` = 0, bits 31..16 of the rounded value are output as they are.
- R13: A cycle with `op_valid` low, or with op code 0 or 7, leaves both accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 idle, 1 load, 2 add, 3 sub, 4 A+B, 5 target−other, 6 negate, 7 idle |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| operand | input | 40 | Signed data operand |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_wide | input | 1 | 0: 32-bit clamp limits, 1: 40-bit clamp limits |
| clr_ovf | input | 1 | Clears both overflow flags |
| rnd_conv | input | 1 | 0 conventional, 1 convergent rounding on store |
| store_sat_en | input | 1 | Clamp the stored word to the signed 16-bit range |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | Sticky overflow flag of A |
| ovf_b | output | 1 | Sticky overflow flag of B |
| store_word | output | 16 | Rounded 16-bit word from the selected accumulator |

## Verification
The assertions check several properties on every cycle:
- The reset values.
- That idle or reserved cycles hold both accumulators.
- That a write never touches the unselected accumulator.
- That a narrow-mode saturated write lands inside the 32-bit range.
- That the overflow flags are sticky and cannot be set by a write with saturation off.

Only the bench's scenarios can show that the arithmetic values are correct, with the exact clamp limits. The same goes for the tie case of convergent rounding and the store clamp. These are compared against values computed in the bench over corner operands in every operation, select and saturation setting.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int ACC_W    = 40;
    localparam int NARROW_W = 32;
    localparam int WORD_W   = 16;
    localparam int RAW_W    = ACC_W + 1;
    localparam int WORD_LSB = NARROW_W - WORD_W;
    localparam int N_ACC    = 2;

    typedef logic [ACC_W-1:0]        acc_t;
    typedef logic signed [RAW_W-1:0] raw_t;
    typedef logic [WORD_W-1:0]       word_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_ADDAB = 3'd4,
        OP_SUBAB = 3'd5,
        OP_NEG   = 3'd6,
        OP_RSVD  = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic sat_en;
        logic wide;
    } sat_cfg_t;

    typedef struct packed {
        acc_t value;
        logic clipped;
    } sat_res_t;

    localparam raw_t LIM_HI_N = {{(RAW_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam raw_t LIM_LO_N = {{(RAW_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
    localparam raw_t LIM_HI_W = {2'b00, {(ACC_W-1){1'b1}}};
    localparam raw_t LIM_LO_W = {2'b11, {(ACC_W-1){1'b0}}};

    function automatic raw_t sext(acc_t v);
        return raw_t'({v[ACC_W-1], v});
    endfunction

endpackage

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
(
    input  acc_op_e op,
    input  logic    sel,
    input  acc_t    operand,
    input  acc_t    acc_a,
    input  acc_t    acc_b,
    output raw_t    raw,
    output logic    writes
);
    raw_t tgt;
    raw_t oth;
    raw_t opd;

    always_comb begin
        tgt    = sel ? sext(acc_b) : sext(acc_a);
        oth    = sel ? sext(acc_a) : sext(acc_b);
        opd    = sext(operand);
        raw    = tgt;
        writes = 1'b1;
        case (op)
            OP_LOAD:  raw = opd;
            OP_ADD:   raw = tgt + opd;
            OP_SUB:   raw = tgt - opd;
            OP_ADDAB: raw = tgt + oth;
            OP_SUBAB: raw = tgt - oth;
            OP_NEG:   raw = -tgt;
            default:  writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat
    import dacc_pkg::*;
(
    input  raw_t     raw,
    input  sat_cfg_t cfg,
    output sat_res_t res
);
    raw_t hi;
    raw_t lo;

    always_comb begin
        hi          = cfg.wide ? LIM_HI_W : LIM_HI_N;
        lo          = cfg.wide ? LIM_LO_W : LIM_LO_N;
        res.value   = raw[ACC_W-1:0];
        res.clipped = 1'b0;
        if (cfg.sat_en) begin
            if (raw > hi) begin
                res.value   = hi[ACC_W-1:0];
                res.clipped = 1'b1;
            end else if (raw < lo) begin
                res.value   = lo[ACC_W-1:0];
                res.clipped = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dacc_store.sv
module dacc_store
    import dacc_pkg::*;
(
    input  acc_t  acc,
    input  logic  conv,
    input  logic  sat_en,
    output word_t word
);
    raw_t ext;
    raw_t inc;
    raw_t rnd;
    logic up;

    always_comb begin
        ext = sext(acc);
        up  = acc[WORD_LSB-1] &&
              (!conv || (|acc[WORD_LSB-2:0]) || acc[WORD_LSB]);
        inc = '0;
        inc[WORD_LSB] = up;
        rnd = ext + inc;
        if (sat_en && (rnd > LIM_HI_N))
            word = {1'b0, {(WORD_W-1){1'b1}}};
        else if (sat_en && (rnd < LIM_LO_N))
            word = {1'b1, {(WORD_W-1){1'b0}}};
        else
            word = rnd[NARROW_W-1:WORD_LSB];
    end
endmodule

// File: rtl/dual_acc_unit.sv
module dual_acc_unit
    import dacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              acc_sel,
    input  logic [ACC_W-1:0]  operand,
    input  logic              sat_en_a,
    input  logic              sat_en_b,
    input  logic              sat_wide,
    input  logic              clr_ovf,
    input  logic              rnd_conv,
    input  logic              store_sat_en,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    output logic              ovf_a,
    output logic              ovf_b,
    output logic [WORD_W-1:0] store_word
);
    raw_t     raw;
    logic     writes;
    sat_cfg_t cfg;
    sat_res_t res;

    dacc_alu u_alu (
        .op      (acc_op_e'(op_code)),
        .sel     (acc_sel),
        .operand (operand),
        .acc_a   (acc_a),
        .acc_b   (acc_b),
        .raw     (raw),
        .writes  (writes)
    );

    always_comb begin
        cfg.sat_en = acc_sel ? sat_en_b : sat_en_a;
        cfg.wide   = sat_wide;
    end

    dacc_sat u_sat (
        .raw (raw),
        .cfg (cfg),
        .res (res)
    );

    for (genvar i = 0; i < N_ACC; i++) begin : g_acc
        acc_t acc_q;
        logic ovf_q;
        logic hit;

        assign hit = op_valid && writes && (acc_sel == 1'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
                ovf_q <= 1'b0;
            end else begin
                if (hit)
                    acc_q <= res.value;
                if (hit && res.clipped)
                    ovf_q <= 1'b1;
                else if (clr_ovf)
                    ovf_q <= 1'b0;
            end
        end
    end

    assign acc_a = g_acc[0].acc_q;
    assign acc_b = g_acc[1].acc_q;
    assign ovf_a = g_acc[0].ovf_q;
    assign ovf_b = g_acc[1].ovf_q;

    dacc_store u_store (
        .acc    (acc_sel ? acc_b : acc_a),
        .conv   (rnd_conv),
        .sat_en (store_sat_en),
        .word   (store_word)
    );
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker
    import dacc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic       acc_sel,
    input logic       sat_en_a,
    input logic       sat_en_b,
    input logic       sat_wide,
    input logic       clr_ovf,
    input acc_t       acc_a,
    input acc_t       acc_b,
    input logic       ovf_a,
    input logic       ovf_b
);
    logic idle;
    logic live;
    assign idle = !op_valid || (op_code == 3'd0) || (op_code == 3'd7);
    assign live = op_valid && (op_code != 3'd0) && (op_code != 3'd7);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_a == '0 && acc_b == '0 && !ovf_a && !ovf_b));

    a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
        idle |=> ($stable(acc_a) && $stable(acc_b)));

    a_r2_b_untouched: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !acc_sel) |=> $stable(acc_b));

    a_r2_a_untouched: assert property (@(posedge clk) disable iff (rst)
        (op_valid && acc_sel) |=> $stable(acc_a));

    a_r6_narrow_range_a: assert property (@(posedge clk) disable iff (rst)
        (live && !acc_sel && sat_en_a && !sat_wide)
        |=> (acc_a[ACC_W-1:NARROW_W-1] == '0 || acc_a[ACC_W-1:NARROW_W-1] == '1));

    a_r6_narrow_range_b: assert property (@(posedge clk) disable iff (rst)
        (live && acc_sel && sat_en_b && !sat_wide)
        |=> (acc_b[ACC_W-1:NARROW_W-1] == '0 || acc_b[ACC_W-1:NARROW_W-1] == '1));

    a_r9_sticky_a: assert property (@(posedge clk) disable iff (rst)
        (ovf_a && !clr_ovf) |=> ovf_a);

    a_r9_sticky_b: assert property (@(posedge clk) disable iff (rst)
        (ovf_b && !clr_ovf) |=> ovf_b);

    a_r5_no_flag_a: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !acc_sel && !sat_en_a && !clr_ovf) |=> (ovf_a == $past(ovf_a)));

    a_r5_no_flag_b: assert property (@(posedge clk) disable iff (rst)
        (op_valid && acc_sel && !sat_en_b && !clr_ovf) |=> (ovf_b == $past(ovf_b)));
endmodule

bind dual_acc_unit dacc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .acc_sel  (acc_sel),
    .sat_en_a (sat_en_a),
    .sat_en_b (sat_en_b),
    .sat_wide (sat_wide),
    .clr_ovf  (clr_ovf),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .ovf_a    (ovf_a),
    .ovf_b    (ovf_b)
);

// File: tb/tb_dual_acc_unit.sv
module tb_dual_acc_unit;
    import dacc_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic        acc_sel;
    logic [39:0] operand;
    logic        sat_en_a, sat_en_b, sat_wide, clr_ovf;
    logic        rnd_conv, store_sat_en;
    logic [39:0] acc_a, acc_b;
    logic        ovf_a, ovf_b;
    logic [15:0] store_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dual_acc_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .operand(operand), .sat_en_a(sat_en_a),
        .sat_en_b(sat_en_b), .sat_wide(sat_wide), .clr_ovf(clr_ovf),
        .rnd_conv(rnd_conv), .store_sat_en(store_sat_en),
        .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
        .store_word(store_word)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [41:0] act, input logic [41:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic longint sx(input logic [39:0] v);
        return longint'(signed'({{24{v[39]}}, v}));
    endfunction

    // returns {clipped, value}
    function automatic logic [40:0] model(input int op, input logic [39:0] t,
                                          input logic [39:0] o, input logic [39:0] d,
                                          input bit sat, input bit wide);
        longint r, hi, lo;
        case (op)
            1: r = sx(d);
            2: r = sx(t) + sx(d);
            3: r = sx(t) - sx(d);
            4: r = sx(t) + sx(o);
            5: r = sx(t) - sx(o);
            default: r = -sx(t);
        endcase
        hi = wide ? 64'sh7F_FFFF_FFFF : 64'sh7FFF_FFFF;
        lo = -hi - 1;
        if (sat && r > hi) return {1'b1, hi[39:0]};
        if (sat && r < lo) return {1'b1, lo[39:0]};
        return {1'b0, r[39:0]};
    endfunction

    function automatic logic [15:0] store_model(input logic [39:0] x, input bit conv,
                                                input bit ssat);
        longint v, low;
        bit up;
        v   = sx(x);
        low = v & 64'hFFFF;
        up  = (low > 64'h8000) || (low == 64'h8000 && (!conv || v[16]));
        if (up) v = v + 64'h1_0000;
        if (ssat && v > 64'sh7FFF_FFFF) return 16'h7FFF;
        if (ssat && v < -64'sh8000_0000) return 16'h8000;
        return v[31:16];
    endfunction

    task automatic op_cycle(input int op, input bit sel, input logic [39:0] d,
                            input bit sa, input bit sb, input bit wide, input bit clr);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'(op); acc_sel = sel; operand = d;
        sat_en_a = sa; sat_en_b = sb; sat_wide = wide; clr_ovf = clr;
        @(negedge clk);
        op_valid = 1'b0; clr_ovf = 1'b0;
    endtask

    logic [39:0] vals [8];
    logic [39:0] svals [8];

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        vals = '{40'h00_0000_0000, 40'h00_0000_0001, 40'hFF_FFFF_FFFF, 40'h00_7FFF_FFFF,
                 40'hFF_8000_0000, 40'h7F_FFFF_FFFF, 40'h80_0000_0000, 40'h00_4000_1234};
        svals = '{40'h00_1234_8000, 40'h00_1235_8000, 40'h00_1234_7FFF, 40'h00_7FFF_8000,
                  40'hFF_FFFF_8000, 40'hFF_8000_0000, 40'h01_0000_0000, 40'hFE_0000_8001};
        rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; acc_sel = 1'b0; operand = '0;
        sat_en_a = 1'b0; sat_en_b = 1'b0; sat_wide = 1'b0; clr_ovf = 1'b0;
        rnd_conv = 1'b0; store_sat_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(acc_a == '0 && acc_b == '0, "R1", "accs after reset", {2'b0, acc_a}, 42'h0);
        check(!ovf_a && !ovf_b, "R1", "flags after reset", {40'b0, ovf_a, ovf_b}, 42'h0);
        rst = 1'b0;

        // R2..R8: sweep of ops, target, saturation setting, corner operand pairs
        for (int op = 1; op <= 6; op++)
            for (int sel = 0; sel < 2; sel++)
                for (int cfg = 0; cfg < 3; cfg++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++) begin
                            logic [39:0] tgt, oth, d, ea, eb;
                            logic [40:0] m;
                            bit st, wd, sa, sb, eoa, eob;
                            string req;
                            op_cycle(1, 1'b0, vals[i], 1'b0, 1'b0, 1'b0, 1'b1);
                            op_cycle(1, 1'b1, vals[j], 1'b0, 1'b0, 1'b0, 1'b0);
                            tgt = sel ? vals[j] : vals[i];
                            oth = sel ? vals[i] : vals[j];
                            d   = vals[(i + j + 3) % 8];
                            st  = (cfg != 0);
                            wd  = (cfg == 2);
                            // R8: the non-target enable is set opposite to the target's
                            sa  = (sel == 0) ? st : !st;
                            sb  = (sel == 1) ? st : !st;
                            op_cycle(op, sel[0], d, sa, sb, wd, 1'b0);
                            m   = model(op, tgt, oth, d, st, wd);
                            ea  = sel ? vals[i] : m[39:0];
                            eb  = sel ? m[39:0] : vals[j];
                            eoa = sel ? 1'b0 : m[40];
                            eob = sel ? m[40] : 1'b0;
                            req = {(op == 1) ? "R2" : ((op <= 3) ? "R3" : "R4"), "/",
                                   (cfg == 0) ? "R5" : ((cfg == 1) ? "R6" : "R7"), "/R8"};
                            check(acc_a == ea && acc_b == eb && ovf_a == eoa && ovf_b == eob,
                                  req, $sformatf("op%0d sel%0d i%0d j%0d", op, sel, i, j),
                                  {ovf_a, ovf_b, sel ? acc_b : acc_a},
                                  {eoa, eob, sel ? eb : ea});
                        end

        // R9: sticky flag survives later writes and clears only on clr_ovf
        op_cycle(1, 1'b0, 40'h00_7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);
        op_cycle(2, 1'b0, 40'h1, 1'b1, 1'b0, 1'b0, 1'b0);
        check(ovf_a && acc_a == 40'h00_7FFF_FFFF, "R9", "flag set on clamp",
              {1'b0, ovf_a, acc_a}, {2'b01, 40'h00_7FFF_FFFF});
        op_cycle(1, 1'b0, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        op_cycle(2, 1'b1, 40'h5, 1'b0, 1'b0, 1'b0, 1'b0);
        check(ovf_a && !ovf_b, "R9", "flag kept", {40'b0, ovf_a, ovf_b}, 42'h2);
        op_cycle(0, 1'b0, 40'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        check(!ovf_a && !ovf_b, "R9", "flag cleared", {40'b0, ovf_a, ovf_b}, 42'h0);
        // clamp in the clearing cycle keeps the flag
        op_cycle(1, 1'b1, 40'h80_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        op_cycle(6, 1'b1, 40'h0, 1'b0, 1'b1, 1'b1, 1'b1);
        check(ovf_b && acc_b == 40'h7F_FFFF_FFFF, "R9", "set wins over clear",
              {1'b0, ovf_b, acc_b}, {2'b01, 40'h7F_FFFF_FFFF});

        // R13: idle and reserved cycles
        op_cycle(1, 1'b0, 40'h5, 1'b0, 1'b0, 1'b0, 1'b0);
        op_cycle(1, 1'b1, 40'h9, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd2; operand = 40'd100; acc_sel = 1'b0;
        @(negedge clk);
        check(acc_a == 40'h5 && acc_b == 40'h9, "R13", "valid low", {2'b0, acc_a}, 42'h5);
        op_cycle(7, 1'b0, 40'd100, 1'b0, 1'b0, 1'b0, 1'b0);
        check(acc_a == 40'h5 && acc_b == 40'h9, "R13", "reserved code", {2'b0, acc_a}, 42'h5);
        op_cycle(0, 1'b1, 40'd100, 1'b0, 1'b0, 1'b0, 1'b0);
        check(acc_a == 40'h5 && acc_b == 40'h9, "R13", "nop code", {2'b0, acc_b}, 42'h9);

        // R10, R11, R12: store rounding and clamp sweep
        for (int k = 0; k < 8; k++) begin
            op_cycle(1, 1'b0, svals[k], 1'b0, 1'b0, 1'b0, 1'b0);
            op_cycle(1, 1'b1, svals[7 - k], 1'b0, 1'b0, 1'b0, 1'b0);
            for (int cv = 0; cv < 2; cv++)
                for (int ss = 0; ss < 2; ss++)
                    for (int sel = 0; sel < 2; sel++) begin
                        logic [15:0] ew;
                        @(negedge clk);
                        rnd_conv = cv[0]; store_sat_en = ss[0]; acc_sel = sel[0];
                        #1;
                        ew = store_model(sel ? svals[7 - k] : svals[k], cv[0], ss[0]);
                        check(store_word == ew,
                              (ss != 0) ? "R12" : ((cv != 0) ? "R11" : "R10"),
                              $sformatf("store k%0d conv%0d sat%0d sel%0d", k, cv, ss, sel),
                              {26'b0, store_word}, {26'b0, ew});
                    end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule